// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the write bus cycles of a two-bank flash device and turns the unlock command sequences written by software into single-cycle start requests for the erase and program engines. Each bus cycle arrives as a one-clock write-valid pulse with a 19-bit address and a 16-bit data word. Every sequence opens with two key cycles. A command cycle follows the keys, and some commands need further cycles. The decoder either fires one request or drops back to idle.

Four array operations come out on `op_start`: word program, sector erase, block erase and bank erase. Each request carries its kind, the target bank, the target address and, for a program, the data word. The decoder also pulses `id_enter` and `id_exit` when the identification read mode is entered or left, and it holds `id_mode` while that mode is active. While the array reports an operation in progress on `busy`, every bus cycle is discarded. Any partial sequence is abandoned at that point.

States: `ST_IDLE` (waiting for the first key), `ST_UNLK1` (first key seen), `ST_UNLK2` (second key seen, expecting a command code), `ST_PROG` (waiting for the program address and data), `ST_ERS1`, `ST_ERS2` and `ST_ERS3` (erase prefix, then the first and second repeated keys). The transitions are:
- key-1 hit moves `ST_IDLE` to `ST_UNLK1`, and `ST_ERS1` to `ST_ERS2`;
- key-2 hit moves `ST_UNLK1` to `ST_UNLK2`, and `ST_ERS2` to `ST_ERS3`;
- program code moves `ST_UNLK2` to `ST_PROG`;
- erase code moves `ST_UNLK2` to `ST_ERS1`;
- identification enter and exit codes go from `ST_UNLK2` back to `ST_IDLE` with a pulse;
- any cycle in `ST_PROG` fires and returns to idle;
- a valid final code in `ST_ERS3` fires and returns to idle;
- every mismatch, and every cycle while busy, returns to `ST_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is idle, `op_start`, `id_enter` and `id_exit` are low, and `id_mode` is low.
- R2: A key-1 cycle (data 0xAA at 0x5555), a key-2 cycle (data 0x55 at 0x2AAA), data 0xA0 at 0x5555, then any fourth cycle pulse `op_start` one clock after that fourth cycle. The pulse has `op_kind`=0, `op_bank`=address bit 18, `op_addr`=address bits 17..0 and `op_data`=the full data word.
- R3: Keys, then 0x80 at 0x5555, then keys again, then a final cycle with data 0x30 at any address produce a sector erase. It has `op_kind`=1, and `op_addr` is address bits 17..10 with bits 9..0 cleared.
- R4: The same prefix with final data 0x50 produces a block erase. It has `op_kind`=2, and `op_addr` is address bits 17..15 with bits 14..0 cleared.
- R5: The same prefix with final data 0x10 at 0x5555 produces a bank erase with `op_kind`=3 and `op_addr`=0. Final data 0x10 at any other address aborts.
- R6: Keys, then 0x90 at 0x5555, pulse `id_enter` and set `id_mode`. Keys, then 0xF0 at 0x5555, pulse `id_exit` and clear `id_mode`. `id_bank` takes address bit 18 of that third cycle.
- R7: Command cycles compare only address bits 14..0 and data bits 7..0. Address bits 17..15 and data bits 15..8 have no effect.
- R8: A cycle with a wrong address or wrong data returns the decoder to idle without a pulse. The cycle right after it may start a new sequence.
- R9: Every cycle written while `busy` is high is discarded and abandons any partial sequence.
- R10: While `id_mode` is high, only the exit command is acted on. Program, erase and enter codes abort with no pulse.
- R11: Pulses last one clock, and at most one of `op_start`, `id_enter` and `id_exit` is high at a time. Clocks without `wr_valid` never advance the sequence.
- R12: The bank of a request is address bit 18 of the final cycle only. Bit 18 in earlier cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-clock pulse marking a bus write cycle |
| wr_addr | input | 19 | Address of the write cycle; bit 18 selects the bank |
| wr_data | input | 16 | Data of the write cycle |
| busy | input | 1 | High while either bank runs an erase or program |
| op_start | output | 1 | One-clock request to start an array operation |
| op_kind | output | 2 | 0 word program, 1 sector, 2 block, 3 bank erase |
| op_bank | output | 1 | Target bank of the request |
| op_addr | output | 18 | Target address within the bank |
| op_data | output | 16 | Word to program (zero for erases) |
| id_enter | output | 1 | One-clock pulse: identification mode entered |
| id_exit | output | 1 | One-clock pulse: identification mode left |
| id_bank | output | 1 | Bank addressed by the last enter or exit |
| id_mode | output | 1 | Identification mode active |

## Verification
The bench sends command cycles with junk in address bits 17..15 and data bits 15..8. A decoder that compared too many bits would never fire on these cycles. It moves bit 18 between earlier cycles and the final one, so a decoder that latched the bank early would report the wrong bank. It injects single bad cycles and follows each with a complete sequence at once. This exposes a decoder that swallows the next cycle or treats the bad cycle as a new start. It also raises `busy` in the middle of a sequence, and tries program, erase and enter codes inside identification mode. A decoder that held a partial sequence across busy, or obeyed non-exit commands in that mode, would then produce pulses the bench does not expect.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_WORD   = 2'd0,
        OP_SECTOR = 2'd1,
        OP_BLOCK  = 2'd2,
        OP_BANK   = 2'd3
    } op_kind_t;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_ID_IN  = 8'h90;
    localparam logic [7:0] CODE_ID_OUT = 8'hF0;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_BLK    = 8'h50;
    localparam logic [7:0] CODE_BANK   = 8'h10;

endpackage

// File: rtl/flash_cmd_match.sv
// Compares one bus cycle against the unlock keys; only the low address
// and data bits take part in the comparison.
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int          CMP_W    = 15,
    parameter int unsigned UNLOCK_A = 'h5555,
    parameter int unsigned UNLOCK_B = 'h2AAA
) (
    input  logic [CMP_W-1:0] cmp_addr,
    input  logic [7:0]       cmp_data,
    output logic             at_a,
    output logic             hit_key1,
    output logic             hit_key2,
    output logic [7:0]       code
);
    localparam logic [CMP_W-1:0] KEY_A = UNLOCK_A[CMP_W-1:0];
    localparam logic [CMP_W-1:0] KEY_B = UNLOCK_B[CMP_W-1:0];

    logic at_b;

    always_comb begin
        at_a     = (cmp_addr == KEY_A);
        at_b     = (cmp_addr == KEY_B);
        code     = cmp_data;
        hit_key1 = at_a && (cmp_data == CODE_KEY1);
        hit_key2 = at_b && (cmp_data == CODE_KEY2);
    end
endmodule

// File: rtl/flash_cmd_target.sv
// Derives the erase-unit base addresses from the in-bank address.
module flash_cmd_target #(
    parameter int TW       = 18,
    parameter int SECT_LSB = 10,
    parameter int BLK_LSB  = 15
) (
    input  logic [TW-1:0] in_addr,
    output logic [TW-1:0] word_addr,
    output logic [TW-1:0] sect_addr,
    output logic [TW-1:0] blk_addr
);
    always_comb begin
        word_addr = in_addr;
        sect_addr = {in_addr[TW-1:SECT_LSB], {SECT_LSB{1'b0}}};
        blk_addr  = {in_addr[TW-1:BLK_LSB], {BLK_LSB{1'b0}}};
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
// Sequence state machine: next-state/fire logic, state register and a
// registered output stage.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int TW     = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              busy,
    input  logic              at_a,
    input  logic              hit_key1,
    input  logic              hit_key2,
    input  logic [7:0]        code,
    input  logic              bank_bit,
    input  logic [TW-1:0]     word_addr,
    input  logic [TW-1:0]     sect_addr,
    input  logic [TW-1:0]     blk_addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              op_start_q,
    output logic [1:0]        op_kind_q,
    output logic              op_bank_q,
    output logic [TW-1:0]     op_addr_q,
    output logic [DATA_W-1:0] op_data_q,
    output logic              id_enter_q,
    output logic              id_exit_q,
    output logic              id_bank_q,
    output logic              id_mode_q
);
    seq_state_t state, nxt;
    op_kind_t   fire_kind;
    logic       fire_op, fire_in, fire_out;

    always_comb begin
        nxt       = state;
        fire_op   = 1'b0;
        fire_in   = 1'b0;
        fire_out  = 1'b0;
        fire_kind = OP_WORD;
        if (wr_valid) begin
            nxt = ST_IDLE;
            if (!busy) begin
                unique case (state)
                    ST_IDLE:  if (hit_key1) nxt = ST_UNLK1;
                    ST_UNLK1: if (hit_key2) nxt = ST_UNLK2;
                    ST_UNLK2: begin
                        if (at_a) begin
                            if (code == CODE_ID_OUT) begin
                                fire_out = 1'b1;
                            end else if (!id_mode_q) begin
                                if (code == CODE_PROG)       nxt = ST_PROG;
                                else if (code == CODE_ERASE) nxt = ST_ERS1;
                                else if (code == CODE_ID_IN) fire_in = 1'b1;
                            end
                        end
                    end
                    ST_PROG: begin
                        fire_op   = 1'b1;
                        fire_kind = OP_WORD;
                    end
                    ST_ERS1: if (hit_key1) nxt = ST_ERS2;
                    ST_ERS2: if (hit_key2) nxt = ST_ERS3;
                    ST_ERS3: begin
                        if (code == CODE_SECT) begin
                            fire_op   = 1'b1;
                            fire_kind = OP_SECTOR;
                        end else if (code == CODE_BLK) begin
                            fire_op   = 1'b1;
                            fire_kind = OP_BLOCK;
                        end else if (code == CODE_BANK && at_a) begin
                            fire_op   = 1'b1;
                            fire_kind = OP_BANK;
                        end
                    end
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start_q <= 1'b0;
            op_kind_q  <= 2'd0;
            op_bank_q  <= 1'b0;
            op_addr_q  <= '0;
            op_data_q  <= '0;
            id_enter_q <= 1'b0;
            id_exit_q  <= 1'b0;
            id_bank_q  <= 1'b0;
            id_mode_q  <= 1'b0;
        end else begin
            op_start_q <= fire_op;
            id_enter_q <= fire_in;
            id_exit_q  <= fire_out;
            if (fire_op) begin
                op_kind_q <= fire_kind;
                op_bank_q <= bank_bit;
                unique case (fire_kind)
                    OP_WORD:   op_addr_q <= word_addr;
                    OP_SECTOR: op_addr_q <= sect_addr;
                    OP_BLOCK:  op_addr_q <= blk_addr;
                    OP_BANK:   op_addr_q <= '0;
                    default:   op_addr_q <= '0;
                endcase
                op_data_q <= (fire_kind == OP_WORD) ? data_in : '0;
            end
            if (fire_in || fire_out) id_bank_q <= bank_bit;
            if (fire_in)       id_mode_q <= 1'b1;
            else if (fire_out) id_mode_q <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int          ADDR_W   = 19,
    parameter int          DATA_W   = 16,
    parameter int          CMP_W    = 15,
    parameter int          SECT_LSB = 10,
    parameter int          BLK_LSB  = 15,
    parameter int unsigned UNLOCK_A = 'h5555,
    parameter int unsigned UNLOCK_B = 'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic              op_bank,
    output logic [ADDR_W-2:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_enter,
    output logic              id_exit,
    output logic              id_bank,
    output logic              id_mode
);
    localparam int TW = ADDR_W - 1;

    logic          at_a, hit_key1, hit_key2;
    logic [7:0]    code;
    logic [TW-1:0] word_addr, sect_addr, blk_addr;

    flash_cmd_match #(
        .CMP_W(CMP_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_match (
        .cmp_addr(wr_addr[CMP_W-1:0]),
        .cmp_data(wr_data[7:0]),
        .at_a(at_a),
        .hit_key1(hit_key1),
        .hit_key2(hit_key2),
        .code(code)
    );

    flash_cmd_target #(
        .TW(TW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
    ) u_target (
        .in_addr(wr_addr[TW-1:0]),
        .word_addr(word_addr),
        .sect_addr(sect_addr),
        .blk_addr(blk_addr)
    );

    flash_cmd_fsm #(
        .TW(TW), .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .wr_valid(wr_valid),
        .busy(busy),
        .at_a(at_a),
        .hit_key1(hit_key1),
        .hit_key2(hit_key2),
        .code(code),
        .bank_bit(wr_addr[ADDR_W-1]),
        .word_addr(word_addr),
        .sect_addr(sect_addr),
        .blk_addr(blk_addr),
        .data_in(wr_data),
        .op_start_q(op_start),
        .op_kind_q(op_kind),
        .op_bank_q(op_bank),
        .op_addr_q(op_addr),
        .op_data_q(op_data),
        .id_enter_q(id_enter),
        .id_exit_q(id_exit),
        .id_bank_q(id_bank),
        .id_mode_q(id_mode)
    );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              op_start,
    input logic [1:0]        op_kind,
    input logic              op_bank,
    input logic [ADDR_W-2:0] op_addr,
    input logic              id_enter,
    input logic              id_exit,
    input logic              id_mode
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_start, id_enter, id_exit})); // R11

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start); // R11

    AST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start || id_enter || id_exit) |-> $past(wr_valid && !busy)); // R9

    AST_WORD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd0) |->
            (op_addr == $past(wr_addr[ADDR_W-2:0]) && op_bank == $past(wr_addr[ADDR_W-1]))); // R2

    AST_ID_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter |-> id_mode); // R6

    AST_ID_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        id_exit |-> !id_mode); // R6

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_enter && !id_exit) |-> $stable(id_mode)); // R6

    AST_ID_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !id_mode); // R10
endmodule

bind flash_cmd_decoder flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .wr_valid(wr_valid),
    .wr_addr(wr_addr),
    .busy(busy),
    .op_start(op_start),
    .op_kind(op_kind),
    .op_bank(op_bank),
    .op_addr(op_addr),
    .id_enter(id_enter),
    .id_exit(id_exit),
    .id_mode(id_mode)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        op_start, op_bank, id_enter, id_exit, id_bank, id_mode;
    logic [1:0]  op_kind;
    logic [17:0] op_addr;
    logic [15:0] op_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_op = 0;
    int n_in = 0;
    int n_out = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .op_start(op_start), .op_kind(op_kind),
        .op_bank(op_bank), .op_addr(op_addr), .op_data(op_data),
        .id_enter(id_enter), .id_exit(id_exit), .id_bank(id_bank), .id_mode(id_mode)
    );

    always @(posedge clk) begin
        #2;
        if (op_start) n_op++;
        if (id_enter) n_in++;
        if (id_exit)  n_out++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic keys(input logic b);
        wr({b, 3'b000, 15'h5555}, 16'h00AA);
        wr({b, 3'b000, 15'h2AAA}, 16'h0055);
    endtask

    task automatic cmd(input logic b, input logic [7:0] c);
        keys(b);
        wr({b, 3'b000, 15'h5555}, {8'h00, c});
    endtask

    task automatic erase_prefix(input logic b);
        cmd(b, 8'h80);
        keys(b);
    endtask

    task automatic t_reset;
        chk(op_start == 0 && id_enter == 0 && id_exit == 0, "R1", "pulses after reset",
            {op_start, id_enter, id_exit}, 0);
        chk(id_mode == 0, "R1", "id_mode after reset", id_mode, 0);
    endtask

    task automatic t_word;
        cmd(1'b0, 8'hA0);
        wr(19'h4_1234, 16'hBEEF);
        chk(op_start == 1, "R2", "op_start", op_start, 1);
        chk(op_kind == 0 && op_bank == 1, "R2", "kind/bank", {op_kind, op_bank}, 3'b001);
        chk(op_addr == 18'h01234, "R2", "addr", op_addr, 18'h01234);
        chk(op_data == 16'hBEEF, "R2", "data", op_data, 16'hBEEF);
        @(negedge clk);
        chk(op_start == 0, "R11", "pulse width", op_start, 0);
    endtask

    task automatic t_sector;
        erase_prefix(1'b0);
        wr(19'h5_A7FF, 16'h0030);
        chk(op_start == 1 && op_kind == 1, "R3", "sector start/kind", {op_start, op_kind}, 3'b101);
        chk(op_addr == 18'h1A400 && op_bank == 1, "R3", "sector addr", op_addr, 18'h1A400);
    endtask

    task automatic t_block;
        erase_prefix(1'b1);
        wr(19'h1_A7FF, 16'h0050);
        chk(op_start == 1 && op_kind == 2, "R4", "block start/kind", {op_start, op_kind}, 3'b110);
        chk(op_addr == 18'h18000 && op_bank == 0, "R4", "block addr/bank", {op_bank, op_addr}, 18'h18000);
    endtask

    task automatic t_bank;
        int c0;
        erase_prefix(1'b0);
        wr(19'h4_5555, 16'h0010);
        chk(op_start == 1 && op_kind == 3, "R5", "bank start/kind", {op_start, op_kind}, 3'b111);
        chk(op_addr == 0 && op_bank == 1, "R5", "bank addr/bank", {op_bank, op_addr}, 19'h40000);
        c0 = n_op;
        erase_prefix(1'b0);
        wr(19'h4_2AAA, 16'h0010);
        @(negedge clk);
        chk(n_op == c0, "R5", "bank erase at wrong address", n_op, c0);
    endtask

    task automatic t_id;
        int c0, e0;
        cmd(1'b1, 8'h90);
        chk(id_enter == 1 && id_bank == 1, "R6", "id_enter/bank", {id_enter, id_bank}, 2'b11);
        chk(id_mode == 1, "R6", "id_mode set", id_mode, 1);
        c0 = n_op; e0 = n_in;
        cmd(1'b0, 8'hA0);
        wr(19'h0_0100, 16'h1234);
        erase_prefix(1'b0);
        wr(19'h0_5555, 16'h0010);
        cmd(1'b0, 8'h90);
        @(negedge clk);
        chk(n_op == c0, "R10", "ops in id mode", n_op, c0);
        chk(n_in == e0 && id_mode == 1, "R10", "re-enter in id mode", n_in, e0);
        cmd(1'b0, 8'hF0);
        chk(id_exit == 1 && id_bank == 0, "R6", "id_exit/bank", {id_exit, id_bank}, 2'b10);
        chk(id_mode == 0, "R6", "id_mode cleared", id_mode, 0);
    endtask

    task automatic t_ignore_bits;
        wr(19'h3_D555, 16'hC3AA);
        wr(19'h3_AAAA, 16'h7755);
        wr(19'h3_D555, 16'hFFA0);
        wr(19'h0_0042, 16'h1111);
        chk(op_start == 1 && op_kind == 0, "R7", "upper bits ignored", {op_start, op_kind}, 3'b100);
        chk(op_addr == 18'h00042 && op_data == 16'h1111, "R7", "payload", op_addr, 18'h00042);
    endtask

    task automatic t_bank_sel;
        wr(19'h4_5555, 16'h00AA);
        wr(19'h4_2AAA, 16'h0055);
        wr(19'h4_5555, 16'h00A0);
        wr(19'h0_0777, 16'h0001);
        chk(op_start == 1 && op_bank == 0, "R12", "bank from final cycle (0)", op_bank, 0);
        erase_prefix(1'b0);
        wr(19'h7_FFFF, 16'h0030);
        chk(op_start == 1 && op_bank == 1, "R12", "bank from final cycle (1)", op_bank, 1);
    endtask

    task automatic t_abort;
        int c0;
        c0 = n_op;
        wr(19'h0_5555, 16'h00AA);
        wr(19'h0_2AAA, 16'h0056);
        cmd(1'b0, 8'hA0);
        wr(19'h0_0010, 16'h00AB);
        chk(op_start == 1 && n_op == c0 + 1, "R8", "restart after bad data", n_op, c0 + 1);
        c0 = n_op;
        wr(19'h0_5554, 16'h00AA);
        keys(1'b0);
        wr(19'h0_5555, 16'h0077);
        erase_prefix(1'b0);
        wr(19'h0_2AAA, 16'h0055);
        wr(19'h0_0000, 16'h0030);
        @(negedge clk);
        chk(n_op == c0, "R8", "bad cycles give no pulse", n_op, c0);
        keys(1'b0);
        wr(19'h0_5555, 16'h00A0);
        wr(19'h0_0020, 16'h0002);
        chk(op_start == 1 && op_addr == 18'h20, "R8", "fresh sequence after aborts", op_addr, 18'h20);
    endtask

    task automatic t_busy;
        int c0, e0;
        c0 = n_op; e0 = n_in;
        cmd(1'b0, 8'hA0);
        busy = 1'b1;
        wr(19'h0_0030, 16'h0003);
        busy = 1'b0;
        wr(19'h0_0030, 16'h0003);
        @(negedge clk);
        chk(n_op == c0, "R9", "program dropped while busy", n_op, c0);
        busy = 1'b1;
        cmd(1'b0, 8'h90);
        busy = 1'b0;
        @(negedge clk);
        chk(n_in == e0 && id_mode == 0, "R9", "id entry dropped while busy", n_in, e0);
    endtask

    task automatic t_gaps;
        keys(1'b0);
        repeat (5) @(negedge clk);
        wr(19'h0_5555, 16'h00A0);
        repeat (3) @(negedge clk);
        wr(19'h0_0099, 16'h0099);
        chk(op_start == 1 && op_addr == 18'h99, "R11", "idle clocks do not advance", op_addr, 18'h99);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_sector();
        t_block();
        t_bank();
        t_id();
        t_ignore_bits();
        t_bank_sel();
        t_abort();
        t_busy();
        t_gaps();
        repeat (2) @(negedge clk);
        report();
    end
endmodule